// File: doc/BRIEF.md
# PHY Side-Register Access Sequencer

This block is a hardware master for a PHY whose configuration registers are not mapped into the system address space. The registers are reached only through a 20-bit control word and a 17-bit status word. A host asks for one 16-bit read or write at a time. The sequencer then breaks the access into its phases: capture the address, capture the data (writes only), and then strobe the read or the write. Each phase is a four-phase handshake. The strobe goes high, the PHY acknowledge goes high, the strobe goes low, and the acknowledge goes low. Every wait for an acknowledge level has a bounded number of polls. If the PHY does not answer in time, the whole access is abandoned with an error.

The request side is a valid/ready port. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and the op, address and write data are latched on that edge. While an access is in flight, `req_ready` stays low. A requester that holds `req_valid` high during that time is back-pressured: its request is neither taken nor remembered. The response side is plain: a one-cycle `done` or `err` pulse, a `busy` level, and `rdata`.

Top module: `phy_regacc`

## Requirements
- R1: The control word carries a 16-bit data/address field in bits 15:0, capture-address at bit 16, capture-data at bit 17, write at bit 18 and read at bit 19. At most one of the four strobes is high in any cycle, and the whole word is zero while idle.
- R2: The acknowledge is bit 16 of the status word. Read data is taken from bits 15:0 of that same word.
- R3: Every access starts with an address phase. The address is driven with no strobe for one cycle, then with capture-address high until the acknowledge is seen high. The address is then driven with no strobe until the acknowledge is seen low. No strobe rises while the acknowledge is still high.
- R4: After the address phase, a read raises only the read strobe, with a zero data field, until the acknowledge is seen high. It then captures bits 15:0 of the status word, drives an all-zero control word until the acknowledge is seen low, and presents the captured value on `rdata` with `done`. `rdata` does not change while idle.
- R5: After the address phase, a write runs a data phase: the data with no strobe for one cycle, then the data with capture-data high, then the data with no strobe, using the same ack-high and ack-low waits as the address phase. It then raises only the write strobe, with a zero data field, until the acknowledge is seen high, and drives the data with no strobe until the acknowledge is seen low.
- R6: In each wait, the acknowledge is sampled once every POLL_GAP cycles. The first sample is POLL_GAP cycles after the wait is entered, and there are at most POLL_LIMIT samples (defaults 4 and 10). The acknowledge must therefore reach the expected level within POLL_LIMIT*POLL_GAP-1 cycles of the wait starting.
- R7: If the last sample in a wait misses, `err` pulses, the control word returns to zero and the sequencer goes idle. With an acknowledge that never rises, `err` comes 1+POLL_LIMIT*POLL_GAP cycles after acceptance.
- R8: `req_ready` is high only while idle. A request presented while busy is ignored and leaves no trace in the PHY registers.
- R9: `busy` is high from the cycle after acceptance until the cycle in which `done` or `err` pulses. `done` and `err` each last one cycle and never coincide.
- R10: `req_ready` is already high in the cycle where `done` or `err` pulses, so the next request can be taken on the edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on handshake timeout |
| rdata | output | 16 | Data of the last completed read |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY (ack and read data) |

## Verification
Two events can share a cycle: the final `done` (or `err`) pulse of one access and the acceptance of the next request. The bench always offers its next request in exactly that cycle. It checks that `req_ready` is high there, and that the new access's address and data fields reach the PHY model intact. It also offers a competing write while an access is busy, and later reads the competing write's target register to confirm that nothing was written.

// File: rtl/phyacc_pkg.sv
package phyacc_pkg;
  localparam int DATA_W   = 16;
  localparam int CTRL_W   = DATA_W + 4;
  localparam int STAT_W   = DATA_W + 1;
  localparam int B_CAPA   = DATA_W;
  localparam int B_CAPD   = DATA_W + 1;
  localparam int B_WSTB   = DATA_W + 2;
  localparam int B_RSTB   = DATA_W + 3;
  localparam int ACK_BIT  = DATA_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ASET, ST_ACAP, ST_AREL,
    ST_DSET, ST_DCAP, ST_DREL,
    ST_WSTB, ST_WREL, ST_RSTB, ST_RREL
  } step_t;
endpackage

// File: rtl/phyacc_poll.sv
module phyacc_poll #(
  parameter int LIMIT = 10,
  parameter int GAP   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic want_hi,
  input  logic ack_in,
  output logic hit,
  output logic timeout
);
  localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam int PW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [GW-1:0] gap_cnt;
  logic [PW-1:0] poll_cnt;
  logic          sample;
  logic          match;

  always_comb begin
    sample  = active && (gap_cnt == GW'(GAP - 1));
    match   = (ack_in == want_hi);
    hit     = sample && match;
    timeout = sample && !match && (poll_cnt == PW'(LIMIT - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt  <= '0;
      poll_cnt <= '0;
    end else if (!active || hit || timeout) begin
      gap_cnt  <= '0;
      poll_cnt <= '0;
    end else if (sample) begin
      gap_cnt  <= '0;
      poll_cnt <= poll_cnt + 1'b1;
    end else begin
      gap_cnt  <= gap_cnt + 1'b1;
    end
  end

  p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (poll_cnt <= PW'(LIMIT - 1)));
endmodule

// File: rtl/phyacc_word.sv
module phyacc_word import phyacc_pkg::*; (
  input  step_t             step,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (step)
      ST_ASET, ST_AREL: ctrl[DATA_W-1:0] = addr;
      ST_ACAP: begin
        ctrl[DATA_W-1:0] = addr;
        ctrl[B_CAPA]     = 1'b1;
      end
      ST_DSET, ST_DREL, ST_WREL: ctrl[DATA_W-1:0] = wdata;
      ST_DCAP: begin
        ctrl[DATA_W-1:0] = wdata;
        ctrl[B_CAPD]     = 1'b1;
      end
      ST_WSTB: ctrl[B_WSTB] = 1'b1;
      ST_RSTB: ctrl[B_RSTB] = 1'b1;
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/phy_regacc.sv
module phy_regacc import phyacc_pkg::*; #(
  parameter int POLL_LIMIT = 10,
  parameter int POLL_GAP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic [CTRL_W-1:0] phy_ctrl,
  input  logic [STAT_W-1:0] phy_stat
);
  step_t             st, st_nx;
  logic              op_wr;
  logic [DATA_W-1:0] addr_q, wdata_q;
  logic              waiting, want_hi, hit, tmo, finish;

  always_comb begin
    waiting = st inside {ST_ACAP, ST_AREL, ST_DCAP, ST_DREL,
                         ST_WSTB, ST_WREL, ST_RSTB, ST_RREL};
    want_hi = st inside {ST_ACAP, ST_DCAP, ST_WSTB, ST_RSTB};
  end

  phyacc_poll #(.LIMIT(POLL_LIMIT), .GAP(POLL_GAP)) u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (waiting),
    .want_hi (want_hi),
    .ack_in  (phy_stat[ACK_BIT]),
    .hit     (hit),
    .timeout (tmo)
  );

  phyacc_word u_word (
    .step  (st),
    .addr  (addr_q),
    .wdata (wdata_q),
    .ctrl  (phy_ctrl)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (req_valid) st_nx = ST_ASET;
      ST_ASET: st_nx = ST_ACAP;
      ST_ACAP: if (hit) st_nx = ST_AREL;
      ST_AREL: if (hit) st_nx = op_wr ? ST_DSET : ST_RSTB;
      ST_DSET: st_nx = ST_DCAP;
      ST_DCAP: if (hit) st_nx = ST_DREL;
      ST_DREL: if (hit) st_nx = ST_WSTB;
      ST_WSTB: if (hit) st_nx = ST_WREL;
      ST_WREL: if (hit) st_nx = ST_IDLE;
      ST_RSTB: if (hit) st_nx = ST_RREL;
      ST_RREL: if (hit) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
    if (tmo) st_nx = ST_IDLE;
    finish = hit && (st == ST_WREL || st == ST_RREL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      op_wr   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= finish;
      err  <= tmo;
      if (st == ST_IDLE && req_valid) begin
        op_wr   <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (st == ST_RSTB && hit) rdata <= phy_stat[DATA_W-1:0];
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);

  p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phy_ctrl[CTRL_W-1:DATA_W]));
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || err));
  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (phy_ctrl == '0));
  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(rdata));
endmodule

// File: tb/tb_phy_regacc.sv
module tb_phy_regacc;
  localparam int LIMIT = 10;
  localparam int GAP   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, busy, done, err;
  logic [15:0] rdata;
  logic [19:0] phy_ctrl;
  logic [16:0] phy_stat;

  int checks = 0, errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  phy_regacc #(.POLL_LIMIT(LIMIT), .POLL_GAP(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] init_val(input int i);
    return 16'h1000 + 16'(i) * 16'h0111;
  endfunction

  // PHY model: ack follows any strobe after lat cycles; mode 1 = ack dead, 2 = ack stuck high
  int          lat = 2;
  int          mode = 0;
  int          lat_cnt = 0;
  logic        ack_m = 1'b0;
  logic [15:0] mdat = '0, maddr = '0, mwd = '0;
  logic [15:0] mem [16];
  logic [19:0] pc_prev = '0;
  logic [15:0] cur_addr = '0, cur_wdata = '0;
  logic [15:0] exp_mem [16];

  assign phy_stat = {ack_m, mdat};

  wire [3:0] stb  = phy_ctrl[19:16];
  wire [3:0] rise = stb & ~pc_prev[19:16];
  wire [3:0] fall = ~stb & pc_prev[19:16];

  initial for (int i = 0; i < 16; i++) begin
    mem[i] = init_val(i);
    exp_mem[i] = init_val(i);
  end

  always @(posedge clk) begin
    pc_prev <= phy_ctrl;
    if (mode == 1) ack_m <= 1'b0;
    else if (mode == 2) ack_m <= 1'b1;
    else if (ack_m == (|stb)) lat_cnt <= 0;
    else if (lat_cnt >= lat - 1) begin ack_m <= |stb; lat_cnt <= 0; end
    else lat_cnt <= lat_cnt + 1;
    if (rst_n && mode == 0) begin
      if (rise != 4'b0) chk(ack_m == 1'b0, "R3 strobe rose with ack high", 32'(ack_m), 0);
      if (rise[0]) begin
        maddr <= phy_ctrl[15:0];
        chk(phy_ctrl[15:0] == cur_addr, "R3 address at capture", 32'(phy_ctrl[15:0]), 32'(cur_addr));
      end
      if (rise[1]) begin
        mwd <= phy_ctrl[15:0];
        chk(phy_ctrl[15:0] == cur_wdata, "R5 data at capture", 32'(phy_ctrl[15:0]), 32'(cur_wdata));
      end
      if (rise[2]) begin
        mem[maddr[3:0]] <= mwd;
        chk(phy_ctrl[15:0] == 16'h0, "R5 write strobe data field", 32'(phy_ctrl[15:0]), 0);
      end
      if (rise[3]) begin
        mdat <= mem[maddr[3:0]];
        chk(phy_ctrl[15:0] == 16'h0, "R4 read strobe data field", 32'(phy_ctrl[15:0]), 0);
      end
      if (fall[0] && !err) chk(phy_ctrl[15:0] == cur_addr, "R3 address held on release", 32'(phy_ctrl[15:0]), 32'(cur_addr));
      if (fall[2] && !err) chk(phy_ctrl[15:0] == cur_wdata, "R5 data on write release", 32'(phy_ctrl[15:0]), 32'(cur_wdata));
      if (fall[3]) chk(phy_ctrl == 20'h0, "R4 word cleared after read", 32'(phy_ctrl), 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Called at a negedge; offers the request at once, so it lands in the done cycle of the previous op
  task automatic do_op(input bit wr, input logic [15:0] a, input logic [15:0] d, input bit intr,
                       output bit e, output logic [15:0] rd, output int n);
    chk(req_ready == 1'b1, "R10 ready in done cycle", 32'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    cur_addr = a; cur_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    chk(busy == 1'b1, "R9 busy after accept", 32'(busy), 1);
    while (!(done || err) && n < 5000) begin
      if (intr && n >= 3 && n <= 6) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 16'h0001; req_wdata = 16'hDEAD;
        chk(req_ready == 1'b0, "R8 ready low while busy", 32'(req_ready), 0);
      end else req_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    e = err;
    rd = rdata;
    chk(busy == 1'b0, "R9 busy low at pulse", 32'(busy), 0);
    chk(!(done && err), "R9 pulses exclusive", {30'b0, done, err}, 0);
  endtask

  task automatic settle();
    repeat (50) @(negedge clk);
  endtask

  initial begin
    bit          e;
    logic [15:0] rd;
    int          n;
    int unsigned seed;
    seed = $urandom(32'd20240611);

    repeat (5) @(negedge clk);
    chk(req_ready == 1'b1 && busy == 1'b0, "R8 reset idle", {30'b0, req_ready, busy}, 2);
    chk(phy_ctrl == 20'h0, "R1 word zero at reset", 32'(phy_ctrl), 0);
    chk(done == 1'b0 && err == 1'b0, "R9 no pulse at reset", {30'b0, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed write then read
    lat = 3;
    do_op(1'b1, 16'hA5C3, 16'h1234, 1'b0, e, rd, n);
    chk(e == 1'b0, "R5 write completes", 32'(e), 0);
    exp_mem[3] = 16'h1234;
    do_op(1'b0, 16'h0003, 16'h0, 1'b0, e, rd, n);
    chk(e == 1'b0 && rd == 16'h1234, "R2 R4 read back", 32'(rd), 32'h1234);
    do_op(1'b0, 16'h7775, 16'h0, 1'b0, e, rd, n);
    chk(rd == init_val(5), "R4 read of untouched register", 32'(rd), 32'(init_val(5)));

    // competing write while busy must be ignored
    do_op(1'b0, 16'h0008, 16'h0, 1'b1, e, rd, n);
    chk(rd == exp_mem[8], "R4 read under intrusion", 32'(rd), 32'(exp_mem[8]));
    do_op(1'b0, 16'h0009, 16'h0, 1'b0, e, rd, n);
    chk(rd == exp_mem[9], "R8 ignored request left register", 32'(rd), 32'(exp_mem[9]));

    // random mix
    for (int k = 0; k < 40; k++) begin
      bit          w;
      logic [15:0] a, d;
      w = 1'($urandom_range(0, 1));
      a = 16'($urandom);
      d = 16'($urandom);
      lat = int'($urandom_range(1, 8));
      do_op(w, a, d, 1'b0, e, rd, n);
      chk(e == 1'b0, "R6 no timeout with short latency", 32'(e), 0);
      if (w) exp_mem[a[3:0]] = d;
      else chk(rd == exp_mem[a[3:0]], "R4 random read", 32'(rd), 32'(exp_mem[a[3:0]]));
    end

    // poll-limit boundary: latency LIMIT*GAP-1 passes, LIMIT*GAP fails
    settle();
    lat = LIMIT * GAP - 1;
    do_op(1'b1, 16'h000B, 16'hBEEF, 1'b0, e, rd, n);
    chk(e == 1'b0, "R6 ack on last poll accepted", 32'(e), 0);
    exp_mem[11] = 16'hBEEF;
    settle();
    lat = LIMIT * GAP;
    do_op(1'b1, 16'h000C, 16'h4242, 1'b0, e, rd, n);
    chk(e == 1'b1, "R6 ack one cycle late times out", 32'(e), 1);
    chk(n == 1 + LIMIT * GAP, "R7 timeout cycle", 32'(n), 32'(1 + LIMIT * GAP));
    chk(phy_ctrl == 20'h0, "R7 word zero after timeout", 32'(phy_ctrl), 0);
    settle();
    lat = 4;
    do_op(1'b0, 16'h000C, 16'h0, 1'b0, e, rd, n);
    chk(rd == exp_mem[12], "R7 aborted write left register", 32'(rd), 32'(exp_mem[12]));
    do_op(1'b0, 16'h000B, 16'h0, 1'b0, e, rd, n);
    chk(rd == 16'hBEEF, "R6 boundary write landed", 32'(rd), 32'hBEEF);

    // dead acknowledge
    settle();
    mode = 1;
    do_op(1'b0, 16'h0002, 16'h0, 1'b0, e, rd, n);
    chk(e == 1'b1 && n == 1 + LIMIT * GAP, "R7 dead ack timeout", 32'(n), 32'(1 + LIMIT * GAP));
    chk(phy_ctrl == 20'h0 && req_ready == 1'b1, "R7 idle after timeout", 32'(phy_ctrl), 0);
    chk(rd == 16'hBEEF, "R4 rdata kept on error", 32'(rd), 32'hBEEF);

    // stuck-high acknowledge: capture hits on first poll, release times out
    settle();
    mode = 2;
    do_op(1'b1, 16'h0004, 16'h5555, 1'b0, e, rd, n);
    chk(e == 1'b1 && n == 1 + GAP + LIMIT * GAP, "R7 stuck ack timeout", 32'(n), 32'(1 + GAP + LIMIT * GAP));
    mode = 0;
    settle();
    do_op(1'b0, 16'h0004, 16'h0, 1'b0, e, rd, n);
    chk(rd == exp_mem[4], "R3 recovery read after errors", 32'(rd), 32'(exp_mem[4]));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule